// File: doc/BRIEF.md
# LPC Memory Cycle Target Decoder

This block sits on the target side of a 4-bit multiplexed LPC bus and recognises the opening of a memory cycle. It samples the active-low frame strobe and the nibble bus on every rising edge of the bus clock. It keeps the nibble seen on the final clock of each low stretch of the strobe, and it accepts a cycle only when that nibble is 0000b. On the first clock with the strobe high, it reads the cycle-type nibble. Bits [3:2] must be 01b, and bit 1 gives the direction. After that, eight address nibbles arrive, most significant first.

When the last address nibble has been taken, the decoder raises a one-clock request strobe. Three fields accompany it: the direction, an array/register selector taken from address bit 23, and address bits [17:0]. Address bits 31:24 and 22:18 play no part. A cycle whose type is not a memory type is dropped with a one-clock reject pulse, and the decoder returns to idle. It never drives the nibble bus. A new low on the strobe during the address phase abandons the cycle in progress, and that low is treated as a fresh start. The turnaround, sync and data phases belong to downstream logic, which uses the request fields.

Top module: `lpc_mem_decoder`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `req_valid`, `busy` and `cyc_reject` are 0. An asynchronous reset in mid-cycle drops `busy` at once, and no request follows.
- R2: The start nibble is the value on `nib_in` at the last rising edge where `frame_n` is 0. Earlier nibbles of the same low stretch have no effect.
- R3: A start nibble other than 0000b produces no request and no reject pulse, whatever follows.
- R4: After a 0000b start, a cycle-type nibble whose bits [3:2] are not 01b produces `cyc_reject` = 1 for exactly the one clock after the cycle-type edge. The decoder then stays idle, with `busy` = 0 and no request.
- R5: In an accepted cycle, `req_write` equals bit 1 of the cycle-type nibble (0 = read, 1 = write). Bit 0 has no effect.
- R6: `busy` is 1 from the clock after an accepted cycle-type nibble until the eighth address nibble has been sampled. `req_valid` rises on the same edge that samples the eighth nibble, and `busy` is 0 in that cycle. Nibbles arrive most significant first.
- R7: While `req_valid` = 1, `req_addr` equals address bits [17:0]. Bits 31:24 and 22:18 have no effect on any output.
- R8: While `req_valid` = 1, `req_array` equals address bit 23 (1 = memory array, 0 = register space).
- R9: `frame_n` = 0 during the address phase aborts the cycle, so `busy` is 0 on the next clock and no request is issued for it. That low stretch is decoded as a new start.
- R10: `req_valid` lasts exactly one clock per accepted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_n | input | 1 | Active-low cycle framing strobe |
| nib_in | input | 4 | Multiplexed nibble bus, sampled only |
| req_valid | output | 1 | One-clock pulse: a memory request has been decoded |
| req_write | output | 1 | Direction of the request, 1 = write |
| req_array | output | 1 | 1 = memory array, 0 = register space |
| req_addr | output | 18 | Local address bits [17:0] |
| busy | output | 1 | Address phase of an accepted cycle in progress |
| cyc_reject | output | 1 | One-clock pulse: non-memory cycle type rejected |

## Verification
The bench builds the decoder with its default parameters: eight address nibbles, an 18-bit local address, the selector at bit 23, start code 0000b and type code 01b. With these values both ignored address bands and the selector sit at fixed positions. Table vectors can therefore set every ignored bit to 1 and still show that the request fields change only with bits 17:0 and bit 23. The directed cases cover long frame lows with a late start nibble, an abort part-way through the address, and a reset in mid-cycle.

// File: rtl/lpc_dec_pkg.sv
package lpc_dec_pkg;

  localparam int NIB_W = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ADDR = 1'b1
  } dec_state_e;

endpackage

// File: rtl/lpc_frame_track.sv
module lpc_frame_track
  import lpc_dec_pkg::*;
#(
  parameter logic [NIB_W-1:0] START_CODE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] nib_in,
  output logic             start_ok
);

  logic             low_q, low_d;
  logic [NIB_W-1:0] start_q, start_d;

  always_comb begin
    low_d   = ~frame_n;
    start_d = start_q;
    if (!frame_n) start_d = nib_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= 1'b0;
      start_q <= '1;
    end else begin
      low_q   <= low_d;
      start_q <= start_d;
    end
  end

  // first high clock after a low stretch: check the nibble of its last low clock
  assign start_ok = low_q & frame_n & (start_q == START_CODE);

  AST_START_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> $past(!frame_n) && frame_n);  // R2

endmodule

// File: rtl/lpc_addr_shift.sv
module lpc_addr_shift
  import lpc_dec_pkg::*;
#(
  parameter int ADDR_NIBS = 8,
  parameter int KEEP_BITS = 18,
  parameter int SEL_BIT   = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 shift_en,
  input  logic [NIB_W-1:0]     nib_in,
  output logic                 last,
  output logic [KEEP_BITS-1:0] addr_keep,
  output logic                 addr_sel
);

  localparam int ADDR_W   = NIB_W * ADDR_NIBS;
  localparam int CNT_W    = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
  localparam int SEL_IDX  = (ADDR_W - 1 - SEL_BIT) / NIB_W;
  localparam int SEL_LANE = SEL_BIT % NIB_W;

  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [KEEP_BITS-1:0] keep_q, keep_d;
  logic                 sel_q, sel_d;
  logic                 sel_hit;

  assign last    = (cnt_q == CNT_W'(ADDR_NIBS - 1));
  assign sel_hit = shift_en && (cnt_q == CNT_W'(SEL_IDX));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (shift_en)      cnt_d = last ? '0 : cnt_q + CNT_W'(1);
  end

  // kept low bits: older nibbles fall off the top as new ones enter
  generate
    if (KEEP_BITS > NIB_W) begin : g_wide
      always_comb begin
        keep_d = keep_q;
        if (shift_en) keep_d = {keep_q[KEEP_BITS-NIB_W-1:0], nib_in};
      end
    end else begin : g_narrow
      always_comb begin
        keep_d = keep_q;
        if (shift_en) keep_d = nib_in[KEEP_BITS-1:0];
      end
    end
  endgenerate

  always_comb begin
    sel_d = sel_q;
    if (sel_hit) sel_d = nib_in[SEL_LANE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      keep_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      keep_q <= keep_d;
      sel_q  <= sel_d;
    end
  end

  assign addr_keep = keep_q;
  assign addr_sel  = sel_q;

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && last && !clr) |=> (cnt_q == '0));  // R6

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));  // R9

endmodule

// File: rtl/lpc_cycle_fsm.sv
module lpc_cycle_fsm
  import lpc_dec_pkg::*;
#(
  parameter logic [1:0] MEM_TYPE = 2'b01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic       start_ok,
  input  logic [3:1] ctype,
  input  logic       last,
  output logic       clr,
  output logic       shift_en,
  output logic       busy,
  output logic       dir_wr,
  output logic       req_pulse,
  output logic       rej_pulse
);

  dec_state_e state_q, state_d;
  logic       dir_q, dir_d;
  logic       val_q, val_d;
  logic       rej_q, rej_d;

  always_comb begin
    state_d  = state_q;
    dir_d    = dir_q;
    val_d    = 1'b0;
    rej_d    = 1'b0;
    clr      = 1'b0;
    shift_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok && (ctype[3:2] == MEM_TYPE)) begin
          state_d = ST_ADDR;
          dir_d   = ctype[1];
          clr     = 1'b1;
        end else if (start_ok) begin
          rej_d = 1'b1;
        end
      end
      ST_ADDR: begin
        if (!frame_n) begin
          state_d = ST_IDLE;
        end else begin
          shift_en = 1'b1;
          if (last) begin
            state_d = ST_IDLE;
            val_d   = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      val_q   <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clr) dir_q <= dir_d;
      val_q   <= val_d;
      rej_q   <= rej_d;
    end
  end

  assign busy      = (state_q == ST_ADDR);
  assign dir_wr    = dir_q;
  assign req_pulse = val_q;
  assign rej_pulse = rej_q;

  AST_REJ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rej_q |-> (state_q == ST_IDLE) && !val_q);  // R4

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    val_q |=> !val_q);  // R10

  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && !frame_n) |=> (state_q == ST_IDLE) && !val_q);  // R9

endmodule

// File: rtl/lpc_mem_decoder.sv
module lpc_mem_decoder
  import lpc_dec_pkg::*;
#(
  parameter int               ADDR_NIBS  = 8,
  parameter int               KEEP_BITS  = 18,
  parameter int               SEL_BIT    = 23,
  parameter logic [NIB_W-1:0] START_CODE = 4'b0000,
  parameter logic [1:0]       MEM_TYPE   = 2'b01
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_n,
  input  logic [NIB_W-1:0]     nib_in,
  output logic                 req_valid,
  output logic                 req_write,
  output logic                 req_array,
  output logic [KEEP_BITS-1:0] req_addr,
  output logic                 busy,
  output logic                 cyc_reject
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       start_ok, last, clr, shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lpc_frame_track #(
    .START_CODE (START_CODE)
  ) i_track (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .frame_n  (frame_n),
    .nib_in   (nib_in),
    .start_ok (start_ok)
  );

  lpc_cycle_fsm #(
    .MEM_TYPE (MEM_TYPE)
  ) i_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .frame_n   (frame_n),
    .start_ok  (start_ok),
    .ctype     (nib_in[3:1]),
    .last      (last),
    .clr       (clr),
    .shift_en  (shift_en),
    .busy      (busy),
    .dir_wr    (req_write),
    .req_pulse (req_valid),
    .rej_pulse (cyc_reject)
  );

  lpc_addr_shift #(
    .ADDR_NIBS (ADDR_NIBS),
    .KEEP_BITS (KEEP_BITS),
    .SEL_BIT   (SEL_BIT)
  ) i_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (clr),
    .shift_en  (shift_en),
    .nib_in    (nib_in),
    .last      (last),
    .addr_keep (req_addr),
    .addr_sel  (req_array)
  );

  AST_ENTRY_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy) |-> $past(frame_n) && !$past(frame_n, 2));  // R2

  AST_REQ_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |-> !busy && $past(busy));  // R6

  AST_NO_DOUBLE_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({req_valid, cyc_reject}));  // R4

endmodule

// File: tb/test_lpc_mem_decoder.sv
module test_lpc_mem_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n;
  logic [3:0]  nib_in;
  logic        req_valid, req_write, req_array, busy, cyc_reject;
  logic [17:0] req_addr;

  int total = 0;
  int bad   = 0;
  int pulses = 0;
  bit done  = 1'b0;
  logic        cap_w, cap_a;
  logic [17:0] cap_addr;

  always #4 clk = ~clk;

  lpc_mem_decoder i_lpc_mem_decoder (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .nib_in(nib_in),
    .req_valid(req_valid), .req_write(req_write), .req_array(req_array),
    .req_addr(req_addr), .busy(busy), .cyc_reject(cyc_reject)
  );

  // {start nibble, cycle-type nibble, 32-bit address}
  localparam logic [39:0] VEC [9] = '{
    {4'h0, 4'b0100, 32'hFFBC_1234},
    {4'h0, 4'b0110, 32'h007F_FFFF},
    {4'h0, 4'b0111, 32'h0080_0000},
    {4'h0, 4'b0101, 32'hFFFF_FFFF},
    {4'h0, 4'b0000, 32'h00AB_CDEF},
    {4'h0, 4'b1100, 32'h0080_0001},
    {4'hD, 4'b0100, 32'h0080_0002},
    {4'h2, 4'b0110, 32'h0080_0003},
    {4'h0, 4'b0110, 32'h12FC_0001}
  };

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic drive_nib(input logic f, input logic [3:0] n);
    @(negedge clk);
    frame_n = f;
    nib_in  = n;
    @(posedge clk);
    #1;
    if (req_valid) begin
      pulses++;
      cap_w    = req_write;
      cap_a    = req_array;
      cap_addr = req_addr;
    end
  endtask

  task automatic run_cycle(input int lows, input logic [3:0] st, input logic [3:0] ct,
                           input logic [31:0] a, input string tag);
    int  p0;
    bit  mem, rej;
    p0  = pulses;
    mem = (st == 4'h0) && (ct[3:2] == 2'b01);
    rej = (st == 4'h0) && !mem;
    for (int i = 0; i < lows - 1; i++) drive_nib(1'b0, 4'hA);
    drive_nib(1'b0, st);
    drive_nib(1'b1, ct);
    check(busy == mem, {tag, " R6 busy after type"}, busy, mem);
    check(cyc_reject == rej, {tag, " R4 reject pulse"}, cyc_reject, rej);
    for (int k = 0; k < 8; k++) begin
      drive_nib(1'b1, a[31-4*k -: 4]);
      if (k == 7 && mem) check(busy == 1'b0, {tag, " R6 busy ends"}, busy, 0);
    end
    check((pulses - p0) == int'(mem), {tag, " R3 request count"}, pulses - p0, mem);
    if (mem) begin
      check(cap_w == ct[1], {tag, " R5 direction"}, cap_w, ct[1]);
      check(cap_a == a[23], {tag, " R8 array select"}, cap_a, a[23]);
      check(cap_addr == a[17:0], {tag, " R7 address"}, cap_addr, a[17:0]);
    end
    drive_nib(1'b1, 4'hF);
    check(req_valid == 1'b0, {tag, " R10 single pulse"}, req_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    rst_n = 1'b0; frame_n = 1'b1; nib_in = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    check(req_valid == 0 && busy == 0 && cyc_reject == 0, "R1 in reset",
          {req_valid, busy, cyc_reject}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(req_valid == 0 && busy == 0 && cyc_reject == 0, "R1 after release",
          {req_valid, busy, cyc_reject}, 0);

    // table walk
    for (int v = 0; v < 9; v++)
      run_cycle(1, VEC[v][39:36], VEC[v][35:32], VEC[v][31:0], $sformatf("vec%0d", v));

    // R2: long low stretch, start on last low clock
    run_cycle(3, 4'h0, 4'b0100, 32'h0081_2345, "R2 long low");

    // R2: zero early in the low stretch, non-zero at its end
    p0 = pulses;
    drive_nib(1'b0, 4'h0);
    drive_nib(1'b0, 4'h5);
    drive_nib(1'b1, 4'b0100);
    check(busy == 0 && cyc_reject == 0, "R2 late non-zero start", {busy, cyc_reject}, 0);
    for (int k = 0; k < 8; k++) drive_nib(1'b1, 4'h8);
    check(pulses == p0, "R2 no request", pulses - p0, 0);

    // R9: abort after three address nibbles, then a new cycle
    p0 = pulses;
    drive_nib(1'b0, 4'h0);
    drive_nib(1'b1, 4'b0100);
    drive_nib(1'b1, 4'h0); drive_nib(1'b1, 4'h0); drive_nib(1'b1, 4'h8);
    drive_nib(1'b0, 4'h0);
    check(busy == 0, "R9 abort drops busy", busy, 0);
    drive_nib(1'b1, 4'b0110);
    check(busy == 1, "R9 restart accepted", busy, 1);
    for (int k = 0; k < 8; k++) drive_nib(1'b1, 32'h0081_2345 >> (28 - 4*k));
    check(pulses - p0 == 1, "R9 one request", pulses - p0, 1);
    check(cap_addr == 18'h12345 && cap_w == 1 && cap_a == 1, "R9 fields of new cycle",
          {cap_w, cap_a, cap_addr}, {2'b11, 18'h12345});

    // R1: reset in mid-cycle
    p0 = pulses;
    drive_nib(1'b0, 4'h0);
    drive_nib(1'b1, 4'b0100);
    drive_nib(1'b1, 4'h0); drive_nib(1'b1, 4'h0);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check(busy == 0 && req_valid == 0, "R1 async reset mid-cycle", {busy, req_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 8; k++) drive_nib(1'b1, 4'h8);
    check(pulses == p0, "R1 no request after reset", pulses - p0, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule